// File: doc/BRIEF.md
# Keyboard/Mouse Controller Host Command Processor

This block is the host-facing front end of a PS/2-style keyboard and mouse controller. The host writes bytes through two strobes that share one byte bus: a command strobe and a data strobe. Command bytes are decoded at once. They can return a reply byte, change a bit of the mode register, move the A20 gate line, or ask for a system reset. Some commands need a parameter. Such a command is remembered as the pending write-command, and the next data-strobe byte is routed by it: into the mode register, into the output port, back out as injected keyboard or auxiliary reply data, or forward to the mouse.

A data byte that arrives with nothing pending goes to the keyboard device. Replies leave on a one-cycle valid/target/byte interface with no backpressure. Bytes bound for a device leave on a second interface of the same kind. The output-port register drives the A20 gate, and writing to it can trigger a reset. The mode byte and the controller status byte are visible as outputs.

Every output is registered, so each write shows its effect in the cycle after the strobe.

Top module: `kbc_host_ctrl`

## Requirements
- R1: After reset the mode byte is 0x03, the status byte is 0x18, the output port reads back 0xCF and A20 is high. No reply, device write, reset pulse or unsupported pulse is active.
- R2: The following commands each put exactly one reply on the keyboard target (replyAux=0) in the cycle after the write:
  - 0x20 replies with the mode byte.
  - 0xAA replies 0x55 and sets status bit 2 (self-test passed).
  - 0xA9 and 0xAB reply 0x00.
  - 0xC0 replies 0x80.
  - 0xD0 replies with the output-port value.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 become the pending write-command, and the next data write is routed by it:
  - 0x60 loads the mode byte.
  - 0xD1 loads the output port.
  - 0xD2 replies the byte on the keyboard target.
  - 0xD3 replies the byte on the auxiliary target (replyAux=1).
  - 0xD4 sends the byte to the mouse (devWrMouse=1).
  - Every data write clears the pending command. Commands that take no parameter leave it unchanged.
- R4: A data write with no pending command sends the byte to the keyboard device (devWrValid=1, devWrMouse=0).
- R5: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4. No other bit changes.
- R6: Command 0xDF sets output-port bit 1 and drives A20 high. Command 0xDD clears that bit and drives A20 low.
- R7: A write to the output port drives A20 from data bit 1, and pulses sysResetReq when data bit 0 is 0.
- R8: Any command whose bits 7..4 are all ones is folded: bit 0 = 0 pulses sysResetReq, and bit 0 = 1 is a no-op that does not raise badCmd.
- R9: Any other unlisted command code pulses badCmd. It gives no reply and no device write, and changes no mode, status or output-port state.
- R10: When the command and data strobes come in the same cycle, the command is carried out and the data byte is dropped.
- R11: Replies, device writes, sysResetReq and badCmd are high only in the cycle that follows a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cmdWr | input | 1 | Command-port write strobe |
| dataWr | input | 1 | Data-port write strobe |
| wrByte | input | 8 | Byte written by the host |
| replyValid | output | 1 | Reply byte valid for one cycle |
| replyAux | output | 1 | Reply target: 0 keyboard queue, 1 auxiliary queue |
| replyByte | output | 8 | Reply byte |
| devWrValid | output | 1 | Byte forwarded to a device, one cycle |
| devWrMouse | output | 1 | Device target: 0 keyboard, 1 mouse |
| devWrByte | output | 8 | Byte forwarded to a device |
| modeByte | output | 8 | Current mode register |
| statusByte | output | 8 | Controller status byte |
| a20Out | output | 1 | A20 gate line |
| sysResetReq | output | 1 | One-cycle system reset request |
| badCmd | output | 1 | One-cycle unsupported-command pulse |

## Verification
Every one of the 256 command codes is issued from a fresh reset. After each one the reply, the fold into reset or no-op, the unsupported pulse and the mode, status and A20 state are compared with a model. This separates the listed codes from their neighbours and from the folded upper range.

Each command is then followed by two data writes. The first shows whether that command left a pending route, and to which target. The second shows that the route was cleared.

A second sweep sends all 256 byte values through the output-port and mode-load paths, reading the output port back. This separates the A20 bit from the reset bit and catches any lost or stuck bit. Simultaneous strobes and single-cycle pulse widths get directed cases.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_RD_MODE   = 8'h20;
  localparam logic [BYTE_W-1:0] CMD_WR_MODE   = 8'h60;
  localparam logic [BYTE_W-1:0] CMD_AUX_OFF   = 8'hA7;
  localparam logic [BYTE_W-1:0] CMD_AUX_ON    = 8'hA8;
  localparam logic [BYTE_W-1:0] CMD_AUX_TEST  = 8'hA9;
  localparam logic [BYTE_W-1:0] CMD_SELF_TEST = 8'hAA;
  localparam logic [BYTE_W-1:0] CMD_KBD_TEST  = 8'hAB;
  localparam logic [BYTE_W-1:0] CMD_KBD_OFF   = 8'hAD;
  localparam logic [BYTE_W-1:0] CMD_KBD_ON    = 8'hAE;
  localparam logic [BYTE_W-1:0] CMD_RD_IN     = 8'hC0;
  localparam logic [BYTE_W-1:0] CMD_RD_OUT    = 8'hD0;
  localparam logic [BYTE_W-1:0] CMD_WR_OUT    = 8'hD1;
  localparam logic [BYTE_W-1:0] CMD_KBD_INJ   = 8'hD2;
  localparam logic [BYTE_W-1:0] CMD_AUX_INJ   = 8'hD3;
  localparam logic [BYTE_W-1:0] CMD_TO_MOUSE  = 8'hD4;
  localparam logic [BYTE_W-1:0] CMD_GATE_OFF  = 8'hDD;
  localparam logic [BYTE_W-1:0] CMD_GATE_ON   = 8'hDF;
  localparam logic [BYTE_W-1:0] CMD_SYS_RST   = 8'hFE;
  localparam logic [BYTE_W-1:0] CMD_NOP       = 8'hFF;
  localparam logic [BYTE_W-1:0] FOLD_MASK     = 8'hF0;

  localparam logic [BYTE_W-1:0] REP_SELF_OK   = 8'h55;
  localparam logic [BYTE_W-1:0] REP_TEST_OK   = 8'h00;
  localparam logic [BYTE_W-1:0] REP_IN_PORT   = 8'h80;

  localparam logic [BYTE_W-1:0] MASK_KBD_DIS  = 8'h10;
  localparam logic [BYTE_W-1:0] MASK_AUX_DIS  = 8'h20;

  localparam int OUT_RST_BIT   = 0;
  localparam int OUT_GATE_BIT  = 1;
  localparam int STAT_TEST_BIT = 2;

  typedef enum logic [2:0] {
    PEND_NONE, PEND_MODE, PEND_OUTP, PEND_KBDQ, PEND_AUXQ, PEND_MOUSE
  } pendKind_t;

  typedef enum logic [1:0] {
    SRC_CONST, SRC_MODE, SRC_OUTP, SRC_BYTE
  } replySrc_t;

  typedef struct packed {
    logic              modeLoad;
    logic              modeSet;
    logic              modeClr;
    logic [BYTE_W-1:0] modeMask;
    logic              outLoad;
    logic              gateUp;
    logic              gateDown;
    logic              selfTest;
    logic              replyEn;
    logic              replyAux;
    replySrc_t         replySrc;
    logic [BYTE_W-1:0] replyConst;
    logic              devFwd;
    logic              devMouse;
    logic              rstReq;
    logic              unknown;
  } ctlStrb_t;
endpackage

// File: rtl/kbc_cmd_ctrl.sv
module kbc_cmd_ctrl
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] wrByte,
  output ctlStrb_t          strb
);
  pendKind_t         pendQ, pendD;
  logic [BYTE_W-1:0] folded;

  // Codes in the top range become reset (even) or no-op (odd).
  always_comb begin
    if ((wrByte & FOLD_MASK) == FOLD_MASK)
      folded = wrByte[0] ? CMD_NOP : CMD_SYS_RST;
    else
      folded = wrByte;
  end

  always_comb begin
    strb  = '0;
    pendD = pendQ;
    if (cmdWr) begin
      case (folded)
        CMD_RD_MODE: begin
          strb.replyEn  = 1'b1;
          strb.replySrc = SRC_MODE;
        end
        CMD_WR_MODE:  pendD = PEND_MODE;
        CMD_WR_OUT:   pendD = PEND_OUTP;
        CMD_KBD_INJ:  pendD = PEND_KBDQ;
        CMD_AUX_INJ:  pendD = PEND_AUXQ;
        CMD_TO_MOUSE: pendD = PEND_MOUSE;
        CMD_AUX_OFF: begin
          strb.modeSet  = 1'b1;
          strb.modeMask = MASK_AUX_DIS;
        end
        CMD_AUX_ON: begin
          strb.modeClr  = 1'b1;
          strb.modeMask = MASK_AUX_DIS;
        end
        CMD_KBD_OFF: begin
          strb.modeSet  = 1'b1;
          strb.modeMask = MASK_KBD_DIS;
        end
        CMD_KBD_ON: begin
          strb.modeClr  = 1'b1;
          strb.modeMask = MASK_KBD_DIS;
        end
        CMD_SELF_TEST: begin
          strb.selfTest   = 1'b1;
          strb.replyEn    = 1'b1;
          strb.replySrc   = SRC_CONST;
          strb.replyConst = REP_SELF_OK;
        end
        CMD_AUX_TEST, CMD_KBD_TEST: begin
          strb.replyEn    = 1'b1;
          strb.replySrc   = SRC_CONST;
          strb.replyConst = REP_TEST_OK;
        end
        CMD_RD_IN: begin
          strb.replyEn    = 1'b1;
          strb.replySrc   = SRC_CONST;
          strb.replyConst = REP_IN_PORT;
        end
        CMD_RD_OUT: begin
          strb.replyEn  = 1'b1;
          strb.replySrc = SRC_OUTP;
        end
        CMD_GATE_ON:  strb.gateUp   = 1'b1;
        CMD_GATE_OFF: strb.gateDown = 1'b1;
        CMD_SYS_RST:  strb.rstReq   = 1'b1;
        CMD_NOP: ;
        default:      strb.unknown  = 1'b1;
      endcase
    end else if (dataWr) begin
      pendD = PEND_NONE;
      case (pendQ)
        PEND_MODE: strb.modeLoad = 1'b1;
        PEND_OUTP: strb.outLoad  = 1'b1;
        PEND_KBDQ: begin
          strb.replyEn  = 1'b1;
          strb.replySrc = SRC_BYTE;
        end
        PEND_AUXQ: begin
          strb.replyEn  = 1'b1;
          strb.replyAux = 1'b1;
          strb.replySrc = SRC_BYTE;
        end
        PEND_MOUSE: begin
          strb.devFwd   = 1'b1;
          strb.devMouse = 1'b1;
        end
        default: strb.devFwd = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= PEND_NONE;
    else       pendQ <= pendD;
  end
endmodule

// File: rtl/kbc_datapath.sv
module kbc_datapath
  import kbc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MODE_RST = 8'h03,
  parameter logic [BYTE_W-1:0] STAT_RST = 8'h18,
  parameter logic [BYTE_W-1:0] OUTP_RST = 8'hCF
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [BYTE_W-1:0] wrByte,
  output logic              replyValid,
  output logic              replyAux,
  output logic [BYTE_W-1:0] replyByte,
  output logic              devWrValid,
  output logic              devWrMouse,
  output logic [BYTE_W-1:0] devWrByte,
  output logic [BYTE_W-1:0] modeByte,
  output logic [BYTE_W-1:0] statusByte,
  output logic              a20Out,
  output logic              sysResetReq,
  output logic              badCmd
);
  logic [BYTE_W-1:0] modeQ, statQ, outQ, replyMux;

  always_comb begin
    unique case (strb.replySrc)
      SRC_MODE: replyMux = modeQ;
      SRC_OUTP: replyMux = outQ;
      SRC_BYTE: replyMux = wrByte;
      default:  replyMux = strb.replyConst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ       <= MODE_RST;
      statQ       <= STAT_RST;
      outQ        <= OUTP_RST;
      replyValid  <= 1'b0;
      replyAux    <= 1'b0;
      replyByte   <= '0;
      devWrValid  <= 1'b0;
      devWrMouse  <= 1'b0;
      devWrByte   <= '0;
      sysResetReq <= 1'b0;
      badCmd      <= 1'b0;
    end else begin
      replyValid  <= strb.replyEn;
      replyAux    <= strb.replyAux;
      replyByte   <= replyMux;
      devWrValid  <= strb.devFwd;
      devWrMouse  <= strb.devMouse;
      devWrByte   <= wrByte;
      sysResetReq <= strb.rstReq | (strb.outLoad & ~wrByte[OUT_RST_BIT]);
      badCmd      <= strb.unknown;
      if (strb.modeLoad)     modeQ <= wrByte;
      else if (strb.modeSet) modeQ <= modeQ | strb.modeMask;
      else if (strb.modeClr) modeQ <= modeQ & ~strb.modeMask;
      if (strb.outLoad)       outQ <= wrByte;
      else if (strb.gateUp)   outQ[OUT_GATE_BIT] <= 1'b1;
      else if (strb.gateDown) outQ[OUT_GATE_BIT] <= 1'b0;
      if (strb.selfTest) statQ[STAT_TEST_BIT] <= 1'b1;
    end
  end

  assign modeByte   = modeQ;
  assign statusByte = statQ;
  assign a20Out     = outQ[OUT_GATE_BIT];
endmodule

// File: rtl/kbc_host_ctrl.sv
module kbc_host_ctrl
  import kbc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MODE_RST = 8'h03,
  parameter logic [BYTE_W-1:0] STAT_RST = 8'h18,
  parameter logic [BYTE_W-1:0] OUTP_RST = 8'hCF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic       dataWr,
  input  logic [7:0] wrByte,
  output logic       replyValid,
  output logic       replyAux,
  output logic [7:0] replyByte,
  output logic       devWrValid,
  output logic       devWrMouse,
  output logic [7:0] devWrByte,
  output logic [7:0] modeByte,
  output logic [7:0] statusByte,
  output logic       a20Out,
  output logic       sysResetReq,
  output logic       badCmd
);
  ctlStrb_t strb;

  kbc_cmd_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .cmdWr  (cmdWr),
    .dataWr (dataWr),
    .wrByte (wrByte),
    .strb   (strb)
  );

  kbc_datapath #(
    .MODE_RST (MODE_RST),
    .STAT_RST (STAT_RST),
    .OUTP_RST (OUTP_RST)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrByte      (wrByte),
    .replyValid  (replyValid),
    .replyAux    (replyAux),
    .replyByte   (replyByte),
    .devWrValid  (devWrValid),
    .devWrMouse  (devWrMouse),
    .devWrByte   (devWrByte),
    .modeByte    (modeByte),
    .statusByte  (statusByte),
    .a20Out      (a20Out),
    .sysResetReq (sysResetReq),
    .badCmd      (badCmd)
  );
endmodule

// File: rtl/kbc_host_ctrl_chk.sv
module kbc_host_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWr,
  input logic       dataWr,
  input logic       replyValid,
  input logic       replyAux,
  input logic       devWrValid,
  input logic [7:0] modeByte,
  input logic       a20Out,
  input logic       sysResetReq,
  input logic       badCmd
);
  // R11: every pulse output traces back to a write strobe one cycle earlier
  a_r11_reply_after_write: assert property (@(posedge clk) disable iff (!rstN)
    replyValid |-> $past(cmdWr || dataWr));
  a_r11_reset_after_write: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(cmdWr || dataWr));
  a_r11_dev_after_data: assert property (@(posedge clk) disable iff (!rstN)
    devWrValid |-> $past(dataWr) && !$past(cmdWr));
  // R9: an unsupported command produces no traffic
  a_r9_bad_is_silent: assert property (@(posedge clk) disable iff (!rstN)
    badCmd |-> !replyValid && !devWrValid && !sysResetReq);
  // R2: command replies always target the keyboard queue
  a_r2_cmd_reply_kbd: assert property (@(posedge clk) disable iff (!rstN)
    (replyValid && $past(cmdWr)) |-> !replyAux);
  // R5: the mode byte only moves after a write
  a_r5_mode_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cmdWr) && !$past(dataWr)) |-> $stable(modeByte));
  // R6: the gate line only moves after a write
  a_r6_gate_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cmdWr) && !$past(dataWr)) |-> $stable(a20Out));
endmodule

bind kbc_host_ctrl kbc_host_ctrl_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdWr       (cmdWr),
  .dataWr      (dataWr),
  .replyValid  (replyValid),
  .replyAux    (replyAux),
  .devWrValid  (devWrValid),
  .modeByte    (modeByte),
  .a20Out      (a20Out),
  .sysResetReq (sysResetReq),
  .badCmd      (badCmd)
);

// File: tb/tb_kbc_host_ctrl.sv
module tb_kbc_host_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdWr = 1'b0;
  logic       dataWr = 1'b0;
  logic [7:0] wrByte = 8'h00;
  logic       replyValid, replyAux, devWrValid, devWrMouse;
  logic [7:0] replyByte, devWrByte, modeByte, statusByte;
  logic       a20Out, sysResetReq, badCmd;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  kbc_host_ctrl dut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .dataWr(dataWr), .wrByte(wrByte),
    .replyValid(replyValid), .replyAux(replyAux), .replyByte(replyByte),
    .devWrValid(devWrValid), .devWrMouse(devWrMouse), .devWrByte(devWrByte),
    .modeByte(modeByte), .statusByte(statusByte), .a20Out(a20Out),
    .sysResetReq(sysResetReq), .badCmd(badCmd)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cmdWr = 1'b0; dataWr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Drive at a falling edge; outputs are sampled at the next falling edge.
  task automatic sendCmd(input logic [7:0] b);
    cmdWr = 1'b1; wrByte = b;
    @(negedge clk);
    cmdWr = 1'b0;
  endtask

  task automatic sendData(input logic [7:0] b);
    dataWr = 1'b1; wrByte = b;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  function automatic bit isKnown(input logic [7:0] c);
    case (c)
      8'h20, 8'h60, 8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE,
      8'hC0, 8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hDD, 8'hDF: return 1'b1;
      default: return c[7:4] == 4'hF;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset();
    @(negedge clk);
    check("R1", "mode", modeByte, 8'h03);
    check("R1", "status", statusByte, 8'h18);
    check("R1", "a20", a20Out, 1);
    check("R1", "pulses", {replyValid, devWrValid, sysResetReq, badCmd}, 0);
    sendCmd(8'hD0);
    check("R1", "outport readback", {replyValid, replyByte}, 9'h1CF);

    // Sweep over all command codes from a fresh reset
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cb = c[7:0];
      bit expRv; logic [7:0] expRb; logic [7:0] expMode; logic [7:0] expStat;
      bit expA20; bit expRst; bit expBad;
      doReset();
      sendCmd(cb);
      expRv = 1'b1; expRb = 8'h00;
      case (cb)
        8'h20: expRb = 8'h03;
        8'hAA: expRb = 8'h55;
        8'hA9, 8'hAB: expRb = 8'h00;
        8'hC0: expRb = 8'h80;
        8'hD0: expRb = 8'hCF;
        default: expRv = 1'b0;
      endcase
      expMode = (cb == 8'hA7) ? 8'h23 : (cb == 8'hAD) ? 8'h13 : 8'h03;
      expStat = (cb == 8'hAA) ? 8'h1C : 8'h18;
      expA20  = (cb != 8'hDD);
      expRst  = (cb[7:4] == 4'hF) && !cb[0];
      expBad  = !isKnown(cb);
      check("R2", $sformatf("reply valid c=%02h", cb), replyValid, expRv);
      if (expRv) begin
        check("R2", $sformatf("reply byte c=%02h", cb), replyByte, expRb);
        check("R2", $sformatf("reply target c=%02h", cb), replyAux, 0);
      end
      check("R8", $sformatf("reset pulse c=%02h", cb), sysResetReq, expRst);
      check("R9", $sformatf("bad pulse c=%02h", cb), badCmd, expBad);
      check("R9", $sformatf("no dev write c=%02h", cb), devWrValid, 0);
      check("R5", $sformatf("mode c=%02h", cb), modeByte, expMode);
      check("R2", $sformatf("status c=%02h", cb), statusByte, expStat);
      check("R6", $sformatf("a20 c=%02h", cb), a20Out, expA20);
      @(negedge clk);
      check("R11", $sformatf("pulses one cycle c=%02h", cb),
            {replyValid, sysResetReq, badCmd}, 0);
      // First data write shows the route this command left (R3, R4)
      sendData(8'h5A);
      case (cb)
        8'h60: begin
          check("R3", "mode load", modeByte, 8'h5A);
          check("R3", "mode load silent", {replyValid, devWrValid}, 0);
        end
        8'hD1: begin
          check("R7", "outport a20 from 5A", a20Out, 1);
          check("R7", "outport reset from 5A", sysResetReq, 1);
        end
        8'hD2: check("R3", "kbd inject", {replyValid, replyAux, replyByte, devWrValid}, {2'b10, 8'h5A, 1'b0});
        8'hD3: check("R3", "aux inject", {replyValid, replyAux, replyByte, devWrValid}, {2'b11, 8'h5A, 1'b0});
        8'hD4: check("R3", "mouse fwd", {devWrValid, devWrMouse, devWrByte, replyValid}, {2'b11, 8'h5A, 1'b0});
        default: begin
          check("R4", $sformatf("kbd fwd c=%02h", cb),
                {devWrValid, devWrMouse, devWrByte, replyValid}, {2'b10, 8'h5A, 1'b0});
          check("R4", $sformatf("mode untouched c=%02h", cb), modeByte, expMode);
        end
      endcase
      // Second data write: pending must be cleared (R3)
      sendData(8'hA5);
      check("R3", $sformatf("pending cleared c=%02h", cb),
            {devWrValid, devWrMouse, devWrByte, replyValid}, {2'b10, 8'hA5, 1'b0});
    end

    // Sweep all data values through output-port and mode paths
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb = v[7:0];
      doReset();
      sendCmd(8'hD1);
      sendData(vb);
      check("R7", $sformatf("a20 v=%02h", vb), a20Out, vb[1]);
      check("R7", $sformatf("reset v=%02h", vb), sysResetReq, !vb[0]);
      sendCmd(8'hD0);
      check("R2", $sformatf("outport read v=%02h", vb), replyByte, vb);
      sendCmd(8'h60);
      sendData(vb);
      check("R3", $sformatf("mode load v=%02h", vb), modeByte, vb);
      sendCmd(8'h20);
      check("R2", $sformatf("mode read v=%02h", vb), replyByte, vb);
    end

    // R5 set then clear, R6 gate up after down
    doReset();
    sendCmd(8'hA7); sendCmd(8'hAD);
    check("R5", "both disables", modeByte, 8'h33);
    sendCmd(8'hA8);
    check("R5", "aux enable", modeByte, 8'h13);
    sendCmd(8'hAE);
    check("R5", "kbd enable", modeByte, 8'h03);
    sendCmd(8'hDD);
    check("R6", "gate down", a20Out, 0);
    sendCmd(8'hDF);
    check("R6", "gate up", a20Out, 1);
    sendCmd(8'hD0);
    check("R6", "outport bit1 restored", replyByte, 8'hCF);

    // R9 unknown command between parameter command and data keeps the route
    doReset();
    sendCmd(8'hD3); sendCmd(8'h00);
    check("R9", "bad pulse", badCmd, 1);
    sendData(8'h11);
    check("R9", "route kept", {replyValid, replyAux, replyByte}, {2'b11, 8'h11});

    // R10 simultaneous strobes: command wins, data dropped
    doReset();
    cmdWr = 1'b1; dataWr = 1'b1; wrByte = 8'hA7;
    @(negedge clk);
    cmdWr = 1'b0; dataWr = 1'b0;
    check("R10", "command applied", modeByte, 8'h23);
    check("R10", "data dropped", devWrValid, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule